// File: doc/BRIEF.md
# Wired-Interrupt Message Bridge

The bridge watches a bank of wired interrupt lines and turns their activity into memory-mapped write requests, so that a downstream interrupt controller can be told about them by message instead of by wire. Every line has its own configuration word. The word sets whether the line is enabled, whether the line is sampled as an edge or as a level, which group the line belongs to, and an 8-bit payload carried in every message for that line. A group decides where the messages go. The level group has two 64-bit destinations: one for "set", sent when the line goes high, and one for "clear", sent when the line goes low. The edge group has a single 64-bit "set" destination and never produces a clear.

Software programs the bridge over a simple 32-bit register port. A read returns its data one cycle after the read strobe. Messages leave on a single valid/ready write channel. When several lines have work waiting, a round-robin pointer picks the next one. Once valid is raised, address and data stay frozen until ready is seen high at a clock edge. The pending flag behind a message is cleared only by that handshake. If a level line goes back to its previous state before its message has been picked, the two events cancel and nothing is sent.

Top module: `irq_msg_bridge`

## Requirements
- R1: Destination registers, each 32 bits and readable: level-set low/high at 0x10/0x14, level-clear low/high at 0x18/0x1C, edge-set low/high at 0x50/0x54. The 64-bit address is {high, low}. Read data appears on the cycle after the read strobe. Unmapped offsets read as zero and ignore writes.
- R2: The configuration word of line n sits at 0x100 + 4*n for n in 0..NUM_IRQ-1. Its fields are bit 24 enable, bit 28 edge mode, bits 31:29 group and bits 7:0 payload. All other bits read back as zero. Offsets past the last line behave as unmapped.
- R3: Reset clears every configuration word, every destination register and all pending work, and holds the valid output low.
- R4: For a line in group 0 with edge mode 0, a rising input sends {level-set address, payload} and a falling input sends {level-clear address, payload}. The data bus carries the payload zero-extended to 32 bits.
- R5: For a line in group 4, a rising input sends one message to the edge-set address, whatever bit 28 holds. A falling input sends nothing.
- R6: For a line in group 0 with edge mode 1, a rising input sends one message to the level-set address, and a falling input sends nothing.
- R7: A line with enable 0, or with a group code other than 0 or 4, sends no messages. Disabling a line drops its work that has not yet been put on the output.
- R8: While valid is high and ready is low, valid, address and data hold steady. A message is consumed on the edge where both are high. After that edge, valid is low for at least one cycle.
- R9: When several lines are waiting, the grant goes to the lowest-numbered waiting line at or above one past the last granted line, wrapping from NUM_IRQ-1 to 0. The pointer starts at 0 after reset.
- R10: Take a level line whose set or clear has not yet been put on the output. If the line returns to its earlier state, the pair cancels and no message is sent. If the first message has already been put on the output, it is sent, and the opposite message follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid the cycle after reg_rd_i |
| irq_i | input | 207 | Wired interrupt lines, asynchronous |
| msg_valid_o | output | 1 | Write request valid |
| msg_ready_i | input | 1 | Write request accepted |
| msg_addr_o | output | 64 | Write request address |
| msg_data_o | output | 32 | Write request data (payload) |

## Verification
The bench lets a level line rise and fall while its set message waits behind a stalled output. A design that mishandles this either sends a stale set with no matching clear, or sends a clear the host never asked for. It repeats the toggle after the set is already on the bus, where a design that cancels too eagerly loses the clear and leaves the host seeing a stuck-high line. Three edges arrive together on lines that straddle the round-robin pointer, including the top line, which exposes a pointer that does not wrap or that restarts from zero. Disabled, invalid-group and edge-group lines are toggled, and the bench checks that the output stays silent. Any stray message shows up as an item the scoreboard never expected.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int REG_W    = 32;
  localparam int PAY_W    = 8;
  localparam int GRP_W    = 3;
  localparam int CFG_BASE = 'h100;
  localparam int EN_BIT   = 24;
  localparam int EDGE_BIT = 28;
  localparam int GRP_LSB  = 29;

  localparam int OFS_LSET_LO = 'h10;
  localparam int OFS_LSET_HI = 'h14;
  localparam int OFS_LCLR_LO = 'h18;
  localparam int OFS_LCLR_HI = 'h1C;
  localparam int OFS_ESET_LO = 'h50;
  localparam int OFS_ESET_HI = 'h54;

  localparam logic [GRP_W-1:0] GRP_LEVEL = 3'd0;
  localparam logic [GRP_W-1:0] GRP_EDGE  = 3'd4;

  typedef enum logic {MSG_SET = 1'b0, MSG_CLR = 1'b1} msg_kind_e;

  typedef struct packed {
    logic             en;
    logic             edge_mode;
    logic [GRP_W-1:0] grp;
    logic [PAY_W-1:0] pay;
  } line_cfg_t;

  function automatic logic [REG_W-1:0] cfg_to_word(input line_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[GRP_LSB +: GRP_W] = c.grp;
    w[EDGE_BIT]         = c.edge_mode;
    w[EN_BIT]           = c.en;
    w[PAY_W-1:0]        = c.pay;
    return w;
  endfunction

  function automatic line_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
    line_cfg_t c;
    c.grp       = w[GRP_LSB +: GRP_W];
    c.edge_mode = w[EDGE_BIT];
    c.en        = w[EN_BIT];
    c.pay       = w[PAY_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/irqm_regs.sv
module irqm_regs
  import irqm_pkg::*;
#(
  parameter int NUM_IRQ = 207,
  parameter int AW      = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic                          rd_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  output logic [REG_W-1:0]              rdata_o,
  output line_cfg_t [NUM_IRQ-1:0]       cfg_o,
  output logic [2*REG_W-1:0]            lset_addr_o,
  output logic [2*REG_W-1:0]            lclr_addr_o,
  output logic [2*REG_W-1:0]            eset_addr_o
);
  localparam int IW      = $clog2(NUM_IRQ);
  localparam int CFG_END = CFG_BASE + 4 * NUM_IRQ;

  line_cfg_t [NUM_IRQ-1:0] cfg_q;
  logic [REG_W-1:0] lset_lo_q, lset_hi_q, lclr_lo_q, lclr_hi_q, eset_lo_q, eset_hi_q;
  logic [REG_W-1:0] rd_val;
  logic [REG_W-1:0] rdata_q;
  logic             cfg_hit;
  logic [IW-1:0]    cfg_idx;

  always_comb begin
    cfg_hit = (addr_i >= AW'(CFG_BASE)) && (addr_i < AW'(CFG_END)) && (addr_i[1:0] == 2'b00);
    cfg_idx = IW'((addr_i - AW'(CFG_BASE)) >> 2);
  end

  always_comb begin
    rd_val = '0;
    if (cfg_hit) begin
      rd_val = cfg_to_word(cfg_q[cfg_idx]);
    end else begin
      case (addr_i)
        AW'(OFS_LSET_LO): rd_val = lset_lo_q;
        AW'(OFS_LSET_HI): rd_val = lset_hi_q;
        AW'(OFS_LCLR_LO): rd_val = lclr_lo_q;
        AW'(OFS_LCLR_HI): rd_val = lclr_hi_q;
        AW'(OFS_ESET_LO): rd_val = eset_lo_q;
        AW'(OFS_ESET_HI): rd_val = eset_hi_q;
        default:          rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      lset_lo_q <= '0;
      lset_hi_q <= '0;
      lclr_lo_q <= '0;
      lclr_hi_q <= '0;
      eset_lo_q <= '0;
      eset_hi_q <= '0;
      rdata_q   <= '0;
    end else begin
      if (wr_i) begin
        if (cfg_hit) begin
          cfg_q[cfg_idx] <= word_to_cfg(wdata_i);
        end else begin
          case (addr_i)
            AW'(OFS_LSET_LO): lset_lo_q <= wdata_i;
            AW'(OFS_LSET_HI): lset_hi_q <= wdata_i;
            AW'(OFS_LCLR_LO): lclr_lo_q <= wdata_i;
            AW'(OFS_LCLR_HI): lclr_hi_q <= wdata_i;
            AW'(OFS_ESET_LO): eset_lo_q <= wdata_i;
            AW'(OFS_ESET_HI): eset_hi_q <= wdata_i;
            default: ;
          endcase
        end
      end
      if (rd_i) begin
        rdata_q <= rd_val;
      end
    end
  end

  assign rdata_o     = rdata_q;
  assign cfg_o       = cfg_q;
  assign lset_addr_o = {lset_hi_q, lset_lo_q};
  assign lclr_addr_o = {lclr_hi_q, lclr_lo_q};
  assign eset_addr_o = {eset_hi_q, eset_lo_q};

  // R1: read data lands only on the cycle after a read strobe
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/irqm_pend_cell.sv
module irqm_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic en_i,
  input  logic edge_i,
  input  logic lock_set_i,
  input  logic lock_clr_i,
  input  logic done_set_i,
  input  logic done_clr_i,
  output logic set_p_o,
  output logic clr_p_o
);
  logic sync1_q, sync2_q, prev_q;
  logic set_q, clr_q;
  logic set_n, clr_n;
  logic rise, fall;

  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;

  always_comb begin
    set_n = set_q & ~done_set_i;
    clr_n = clr_q & ~done_clr_i;
    if (!en_i) begin
      if (!lock_set_i) set_n = 1'b0;
      if (!lock_clr_i) clr_n = 1'b0;
    end else if (edge_i) begin
      if (rise) set_n = 1'b1;
      if (!lock_clr_i) clr_n = 1'b0;
    end else begin
      if (rise) begin
        if (clr_n && !lock_clr_i) clr_n = 1'b0;
        else                      set_n = 1'b1;
      end else if (fall) begin
        if (set_n && !lock_set_i) set_n = 1'b0;
        else                      clr_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      set_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      sync1_q <= irq_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      set_q   <= set_n;
      clr_q   <= clr_n;
    end
  end

  assign set_p_o = set_q;
  assign clr_p_o = clr_q;

  // R7: a disabled line with nothing on the bus keeps no work
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !lock_set_i && !lock_clr_i) |=> (!set_q && !clr_q));

  // R10: both directions wait together only while one of them is on the bus
  p_pair_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_set_i && !lock_clr_i) |-> !(set_q && clr_q));
endmodule

// File: rtl/irqm_rr_arb.sv
module irqm_rr_arb #(
  parameter int N = 207
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_i,
  input  logic                 take_i,
  output logic                 gnt_valid_o,
  output logic [$clog2(N)-1:0] gnt_idx_o
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q;
  logic          found;
  logic [IW-1:0] gnt;

  always_comb begin
    found = 1'b0;
    gnt   = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req_i[idx]) begin
        found = 1'b1;
        gnt   = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (take_i && found) begin
      ptr_q <= (gnt == IW'(N - 1)) ? '0 : gnt + 1'b1;
    end
  end

  assign gnt_valid_o = found;
  assign gnt_idx_o   = gnt;

  // R9: any waiting line yields a grant
  p_work_conserving_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> gnt_valid_o);
  // R9: the grant always names a waiting line
  p_grant_is_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> req_i[gnt_idx_o]);
endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge
  import irqm_pkg::*;
#(
  parameter int NUM_IRQ = 207,
  parameter int AW      = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o
);
  localparam int IW   = $clog2(NUM_IRQ);
  localparam int MAW  = 2 * REG_W;

  line_cfg_t [NUM_IRQ-1:0] cfg;
  logic [MAW-1:0] lset_addr, lclr_addr, eset_addr;

  logic [NUM_IRQ-1:0] set_p, clr_p, lock_set, lock_clr, done_set, done_clr;
  logic [NUM_IRQ-1:0] en_eff, edge_eff;

  logic            gnt_valid;
  logic [IW-1:0]   gnt_idx;
  logic            load, done;
  msg_kind_e       load_kind;
  logic [MAW-1:0]  load_addr;

  logic            slot_valid_q;
  logic [IW-1:0]   slot_idx_q;
  msg_kind_e       slot_kind_q;
  logic [MAW-1:0]  slot_addr_q;
  logic [REG_W-1:0] slot_data_q;

  irqm_regs #(.NUM_IRQ(NUM_IRQ), .AW(AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .cfg_o       (cfg),
    .lset_addr_o (lset_addr),
    .lclr_addr_o (lclr_addr),
    .eset_addr_o (eset_addr)
  );

  assign done      = slot_valid_q && msg_ready_i;
  assign load      = !slot_valid_q && gnt_valid;
  assign load_kind = set_p[gnt_idx] ? MSG_SET : MSG_CLR;

  always_comb begin
    if (load_kind == MSG_CLR)                load_addr = lclr_addr;
    else if (cfg[gnt_idx].grp == GRP_EDGE)   load_addr = eset_addr;
    else                                     load_addr = lset_addr;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic in_slot, in_load;
    assign in_slot     = slot_valid_q && (slot_idx_q == IW'(i));
    assign in_load     = load && (gnt_idx == IW'(i));
    assign lock_set[i] = (in_slot && slot_kind_q == MSG_SET) || (in_load && load_kind == MSG_SET);
    assign lock_clr[i] = (in_slot && slot_kind_q == MSG_CLR) || (in_load && load_kind == MSG_CLR);
    assign done_set[i] = done && in_slot && (slot_kind_q == MSG_SET);
    assign done_clr[i] = done && in_slot && (slot_kind_q == MSG_CLR);
    assign en_eff[i]   = cfg[i].en && ((cfg[i].grp == GRP_LEVEL) || (cfg[i].grp == GRP_EDGE));
    assign edge_eff[i] = cfg[i].edge_mode || (cfg[i].grp == GRP_EDGE);

    irqm_pend_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_i      (irq_i[i]),
      .en_i       (en_eff[i]),
      .edge_i     (edge_eff[i]),
      .lock_set_i (lock_set[i]),
      .lock_clr_i (lock_clr[i]),
      .done_set_i (done_set[i]),
      .done_clr_i (done_clr[i]),
      .set_p_o    (set_p[i]),
      .clr_p_o    (clr_p[i])
    );
  end

  irqm_rr_arb #(.N(NUM_IRQ)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (set_p | clr_p),
    .take_i      (!slot_valid_q),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid_q <= 1'b0;
      slot_idx_q   <= '0;
      slot_kind_q  <= MSG_SET;
      slot_addr_q  <= '0;
      slot_data_q  <= '0;
    end else if (load) begin
      slot_valid_q <= 1'b1;
      slot_idx_q   <= gnt_idx;
      slot_kind_q  <= load_kind;
      slot_addr_q  <= load_addr;
      slot_data_q  <= REG_W'(cfg[gnt_idx].pay);
    end else if (done) begin
      slot_valid_q <= 1'b0;
    end
  end

  assign msg_valid_o = slot_valid_q;
  assign msg_addr_o  = slot_addr_q;
  assign msg_data_o  = slot_data_q;

  // R8: request frozen under back-pressure
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));
  // R8: one idle cycle follows every handshake
  p_gap_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && msg_ready_i) |=> !msg_valid_o);
endmodule

// File: tb/sim_irq_msg_bridge.sv
module sim_irq_msg_bridge;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [206:0] irq = '0;
  logic         msg_valid, msg_ready = 1'b0;
  logic [63:0]  msg_addr;
  logic [31:0]  msg_data;

  always #5 clk = ~clk;

  irq_msg_bridge u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_i(irq), .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  localparam logic [63:0] LSET = 64'h0000_00AB_F000_0040;
  localparam logic [63:0] LCLR = 64'h0000_00AB_F000_0048;
  localparam logic [63:0] ESET = 64'h0000_00CD_E000_0050;

  int checks = 0, fails = 0;
  int rmode = 0;
  int tick = 0;
  logic [63:0] exp_a[$];
  logic [31:0] exp_d[$];
  string       exp_r[$];

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_msg(input logic [63:0] a, input logic [7:0] d, input string req);
    exp_a.push_back(a);
    exp_d.push_back({24'h0, d});
    exp_r.push_back(req);
  endtask

  // scoreboard monitor and ready driver
  always @(negedge clk) begin
    logic nr;
    logic [63:0] ea;
    logic [31:0] ed;
    string er;
    if (rst_n) begin
      tick++;
      nr = (rmode == 0) ? 1'b1 : ((rmode == 1) ? 1'b0 : tick[0]);
      if (msg_valid && nr) begin
        if (exp_a.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R7 unexpected message actual=%h expected=none", {msg_addr, msg_data});
        end else begin
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          er = exp_r.pop_front();
          chk(msg_addr == ea && msg_data == ed, er, {msg_addr, msg_data}, {ea, ed});
        end
      end
      msg_ready <= nr;
    end else begin
      msg_ready <= 1'b0;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rdata == e, req, {64'h0, reg_rdata}, {64'h0, e});
  endtask

  function automatic logic [11:0] cfg_of(input int n);
    return 12'(32'h100 + 4 * n);
  endfunction

  task automatic set_irq(input int n, input logic v);
    @(negedge clk);
    irq[n] = v;
  endtask

  task automatic drain(input string req);
    int n;
    n = 0;
    while (exp_a.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    wait_cyc(10);
    chk(exp_a.size() == 0, req, 96'(exp_a.size()), 96'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired R8 actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(5);
    // R3: reset state
    chk(msg_valid == 1'b0, "R3", {95'h0, msg_valid}, 96'h0);
    rst_n = 1'b1;
    rd_chk(cfg_of(5), 32'h0, "R3");
    rd_chk(12'h10, 32'h0, "R3");

    // R1: destination registers
    wr(12'h10, LSET[31:0]); wr(12'h14, LSET[63:32]);
    wr(12'h18, LCLR[31:0]); wr(12'h1C, LCLR[63:32]);
    wr(12'h50, ESET[31:0]); wr(12'h54, ESET[63:32]);
    wr(12'h20, 32'hDEAD_BEEF); wr(12'h58, 32'h1234_5678);
    rd_chk(12'h14, LSET[63:32], "R1");
    rd_chk(12'h18, LCLR[31:0], "R1");
    rd_chk(12'h54, ESET[63:32], "R1");
    rd_chk(12'h20, 32'h0, "R1");
    rd_chk(12'h58, 32'h0, "R1");

    // R2: configuration words
    wr(cfg_of(5),   32'h0F1F_FF25);
    wr(cfg_of(9),   32'h8100_0039);
    wr(cfg_of(12),  32'h1100_0052);
    wr(cfg_of(40),  32'h1000_0011);
    wr(cfg_of(41),  32'h4100_0041);
    wr(cfg_of(206), 32'h8100_00C6);
    wr(cfg_of(3),   32'h8100_0003);
    wr(cfg_of(100), 32'h8100_0064);
    wr(cfg_of(20),  32'h0100_0014);
    wr(cfg_of(30),  32'h0100_001E);
    wr(cfg_of(207), 32'h8100_00FF);
    rd_chk(cfg_of(5),   32'h0100_0025, "R2");
    rd_chk(cfg_of(41),  32'h4100_0041, "R2");
    rd_chk(cfg_of(206), 32'h8100_00C6, "R2");
    rd_chk(cfg_of(207), 32'h0, "R2");

    // R4: level pair under toggling ready
    rmode = 2;
    expect_msg(LSET, 8'h25, "R4");
    set_irq(5, 1'b1); wait_cyc(12);
    expect_msg(LCLR, 8'h25, "R4");
    set_irq(5, 1'b0); wait_cyc(12);
    drain("R4");

    // R5: edge group, no clear on fall
    rmode = 0;
    expect_msg(ESET, 8'h39, "R5");
    set_irq(9, 1'b1); wait_cyc(10);
    set_irq(9, 1'b0); wait_cyc(10);
    drain("R5");

    // R6: level group in edge mode
    expect_msg(LSET, 8'h52, "R6");
    set_irq(12, 1'b1); wait_cyc(10);
    set_irq(12, 1'b0); wait_cyc(10);
    drain("R6");

    // R7: disabled and invalid group stay silent
    set_irq(40, 1'b1); set_irq(41, 1'b1); wait_cyc(10);
    set_irq(40, 1'b0); set_irq(41, 1'b0); wait_cyc(20);
    chk(msg_valid == 1'b0, "R7", {95'h0, msg_valid}, 96'h0);
    drain("R7");

    // R9: round robin from pointer 13 wraps through 206 to 3
    rmode = 1;
    expect_msg(ESET, 8'h64, "R9");
    expect_msg(ESET, 8'hC6, "R9");
    expect_msg(ESET, 8'h03, "R9");
    @(negedge clk);
    irq[206] = 1'b1; irq[3] = 1'b1; irq[100] = 1'b1;
    wait_cyc(10);
    // R8: request held while stalled
    chk(msg_valid && msg_addr == ESET && msg_data == 32'h64, "R8",
        {msg_addr, msg_data}, {ESET, 32'h64});
    wait_cyc(5);
    chk(msg_valid && msg_addr == ESET && msg_data == 32'h64, "R8",
        {msg_addr, msg_data}, {ESET, 32'h64});
    rmode = 0;
    drain("R9");
    @(negedge clk);
    irq[206] = 1'b0; irq[3] = 1'b0; irq[100] = 1'b0;
    wait_cyc(10);

    // R10: cancellation while waiting behind a stalled slot
    rmode = 1;
    expect_msg(ESET, 8'h39, "R10");
    set_irq(9, 1'b1); wait_cyc(8);
    set_irq(20, 1'b1); wait_cyc(6);
    set_irq(20, 1'b0); wait_cyc(6);
    // R7: disabling drops pending work
    set_irq(30, 1'b1); wait_cyc(6);
    wr(cfg_of(30), 32'h0);
    wait_cyc(4);
    rmode = 0;
    drain("R10");
    set_irq(9, 1'b0); set_irq(30, 1'b0); wait_cyc(10);
    chk(msg_valid == 1'b0, "R7", {95'h0, msg_valid}, 96'h0);

    // R10: opposite event after the set is already on the bus
    rmode = 1;
    expect_msg(LSET, 8'h14, "R10");
    set_irq(20, 1'b1); wait_cyc(8);
    expect_msg(LCLR, 8'h14, "R10");
    set_irq(20, 1'b0); wait_cyc(8);
    rmode = 0;
    drain("R10");

    // R3: reset again wipes configuration
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    chk(msg_valid == 1'b0, "R3", {95'h0, msg_valid}, 96'h0);
    rd_chk(cfg_of(9), 32'h0, "R3");
    rd_chk(12'h50, 32'h0, "R3");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule